// File: doc/BRIEF.md
# Low-power aware SPI byte master

The block is a byte-wide SPI master for a small controller. It makes its own serial clock from the system clock, shifts each byte MSB first, and drives four active-low slave selects from a mask that software writes. Software reaches the block through four register slots. Writing the data slot starts a send. Any number of slaves may listen to a send, so one send can reach several of them at once. Writing the status slot starts an exchange that keeps the received byte. An exchange is refused unless exactly one slave is selected, so that two slaves never drive MISO together.

The block handles three system power and reset conditions. While the CPU waits, the block keeps shifting and can raise its completion interrupt to wake the CPU. A stop request gates the baud generator. A byte in progress then freezes at its current bit, and it resumes from that bit once the stop request drops. Reset clears every register and disables the block. Reset also covers the case where a stopped system is woken by reset. While reset is low, all slave selects stay high.

Top module: `spi_lp_master`

## Requirements
- R1: After reset, the control, mask, status and received-data slots read 0, every `ss_no` line is high, `sclk_o` is low and `irq_o` is low. The slots are addressed by `addr_i`: 0 is data, 1 is control, 2 is select mask, 3 is status.
- R2: Control bit 0 enables the block and control bit 1 enables the interrupt. While the block is enabled, `ss_no` is the inverse of the 4-bit mask in slot 2. While the block is disabled, all four select lines are high.
- R3: Writing slot 0 while the block is enabled and idle sends the written byte MSB first over 8 SCLK periods. `sclk_o` idles low and each half period lasts DIV_HALF clocks. MOSI changes after falling edges and MISO is sampled on rising edges. The completion flag sets 16*DIV_HALF clocks after the write edge. A send does not alter the received-data slot.
- R4: Writing slot 3 while the block is enabled and idle, with exactly one mask bit set, runs an exchange. The byte taken from MISO then reads back from slot 0.
- R5: Writing slot 3 with zero or more than one mask bit set starts no transfer, leaves `sclk_o` low and sets status bit 1. Reading slot 3 clears status bit 1.
- R6: While a transfer is in progress, writes to the mask and further start requests are ignored.
- R7: Status bit 0 sets when the eighth bit completes and clears when slot 0 is read. `irq_o` is high exactly when status bit 0 and the interrupt enable are both set. Status bit 2 reads 1 while a transfer is in progress.
- R8: `wait_i` has no effect: with it high, a transfer finishes in the same time and raises `irq_o`.
- R9: While `stop_i` is high, `sclk_o`, `mosi_o` and the bit position hold still. After `stop_i` drops, the transfer resumes from that bit and finishes with the correct bytes.
- R10: Asserting reset while stopped in mid-transfer holds all selects high, and leaves the block in its R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wait_i | input | 1 | CPU wait state indication |
| stop_i | input | 1 | Stop request; gates the baud generator |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (for read side effects) |
| addr_i | input | 2 | Register slot select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed slot |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | 4 | Active-low slave selects |
| irq_o | output | 1 | Transfer-complete interrupt |

## Verification
The stop-freeze property assumes that stop is only requested while the block stays enabled. It also assumes that a transfer is not started in the same cycle a stop request arrives. The stimulus therefore raises `stop_i` only after a transfer is running, and it never writes control during a stop. Read and write strobes are single-cycle and never overlap. MISO is driven by a bench slave model that changes its bit only after falling SCLK edges, which is the timing the sampling edge relies on.

// File: rtl/spi_lp_pkg.sv
package spi_lp_pkg;
  typedef enum logic [1:0] {
    SLOT_DATA = 2'd0,
    SLOT_CTRL = 2'd1,
    SLOT_MASK = 2'd2,
    SLOT_STAT = 2'd3
  } slot_e;

  localparam int CTRL_EN = 0;
  localparam int CTRL_IE = 1;
  localparam int STAT_DONE = 0;
  localparam int STAT_ERR  = 1;
  localparam int STAT_BUSY = 2;
endpackage

// File: rtl/spi_lp_baud.sv
module spi_lp_baud #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic stop_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!stop_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // stop gates the generator: no tick, counter frozen
  assign tick_o = run_i && !stop_i && (cnt_q == LAST);
endmodule

// File: rtl/spi_lp_shift.sv
module spi_lp_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [DW-1:0] tx_i,
  input  logic          tick_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic [DW-1:0] sh_q;
  logic [BW-1:0] bit_q;
  logic          smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      sclk_o <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      smp_q  <= 1'b0;
    end else if (abort_i) begin
      busy_o <= 1'b0;
      sclk_o <= 1'b0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      sclk_o <= 1'b0;
      bit_q  <= '0;
      sh_q   <= tx_i;
    end else if (busy_o && tick_i) begin
      if (!sclk_o) begin
        sclk_o <= 1'b1;
        smp_q  <= miso_i;
      end else begin
        sclk_o <= 1'b0;
        sh_q   <= {sh_q[DW-2:0], smp_q};
        bit_q  <= bit_q + 1'b1;
        if (bit_q == LAST_BIT) busy_o <= 1'b0;
      end
    end
  end

  assign mosi_o = sh_q[DW-1];
  assign done_o = busy_o && tick_i && sclk_o && (bit_q == LAST_BIT) && !abort_i;
  // byte as it will stand after the final shift
  assign rx_o   = {sh_q[DW-2:0], smp_q};

  assert_sclk_idle_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
endmodule

// File: rtl/spi_lp_master.sv
module spi_lp_master
  import spi_lp_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int DATA_W   = 8,
  parameter int NUM_SS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wait_i,
  input  logic              stop_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_no,
  output logic              irq_o
);
  logic              en_q, ie_q, done_q, err_q, is_rd_q;
  logic [NUM_SS-1:0] mask_q;
  logic [DATA_W-1:0] rx_q;
  logic              tick, eng_busy, eng_done;
  logic [DATA_W-1:0] eng_rx;
  logic              wr_data, wr_ctrl, wr_mask, wr_stat, rd_data, rd_stat;
  logic              one_sel, can_go, start_wr, start_rd, bad_rd;

  assign wr_data = wr_en_i && (addr_i == SLOT_DATA);
  assign wr_ctrl = wr_en_i && (addr_i == SLOT_CTRL);
  assign wr_mask = wr_en_i && (addr_i == SLOT_MASK);
  assign wr_stat = wr_en_i && (addr_i == SLOT_STAT);
  assign rd_data = rd_en_i && (addr_i == SLOT_DATA);
  assign rd_stat = rd_en_i && (addr_i == SLOT_STAT);

  assign one_sel  = ($countones(mask_q) == 1);
  assign can_go   = en_q && !eng_busy;
  assign start_wr = wr_data && can_go;
  assign start_rd = wr_stat && can_go && one_sel;
  assign bad_rd   = wr_stat && can_go && !one_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      mask_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      is_rd_q <= 1'b0;
      rx_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q <= wdata_i[CTRL_EN];
        ie_q <= wdata_i[CTRL_IE];
      end
      if (wr_mask && !eng_busy) mask_q <= wdata_i[NUM_SS-1:0];
      if (start_wr || start_rd) is_rd_q <= start_rd;
      if (eng_done) done_q <= 1'b1;
      else if (rd_data) done_q <= 1'b0;
      if (bad_rd) err_q <= 1'b1;
      else if (rd_stat) err_q <= 1'b0;
      if (eng_done && is_rd_q) rx_q <= eng_rx;
    end
  end

  spi_lp_baud #(.HALF(DIV_HALF)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (eng_busy),
    .stop_i(stop_i),
    .tick_o(tick)
  );

  spi_lp_shift #(.DW(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_wr || start_rd),
    .abort_i(!en_q),
    .tx_i   (wdata_i),
    .tick_i (tick),
    .miso_i (miso_i),
    .busy_o (eng_busy),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .done_o (eng_done),
    .rx_o   (eng_rx)
  );

  assign ss_no = en_q ? ~mask_q : '1;
  assign irq_o = done_q && ie_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      SLOT_DATA: rdata_o = rx_q;
      SLOT_CTRL: begin
        rdata_o[CTRL_EN] = en_q;
        rdata_o[CTRL_IE] = ie_q;
      end
      SLOT_MASK: rdata_o[NUM_SS-1:0] = mask_q;
      default: begin
        rdata_o[STAT_DONE] = done_q;
        rdata_o[STAT_ERR]  = err_q;
        rdata_o[STAT_BUSY] = eng_busy;
      end
    endcase
  end

  assert_read_single_select_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_busy && is_rd_q && en_q) |-> ($countones(~ss_no) == 1));
  assert_bad_read_no_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && en_q && !eng_busy && ($countones(mask_q) != 1)) |=> (!eng_busy && err_q));
  assert_done_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |=> done_q);
  assert_wait_keeps_running_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && eng_done) |=> (done_q && !eng_busy));
  assert_stop_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && eng_busy && en_q) |=> ($stable(sclk_o) && $stable(mosi_o)));
endmodule

// File: tb/spi_lp_master_bench.sv
module spi_lp_master_bench;
  localparam int HALF = 2;
  localparam int XFER = 16 * HALF;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wait_i = 1'b0, stop_i = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       sclk_o, mosi_o, miso_i, irq_o;
  logic [3:0] ss_no;

  int tests = 0, fails = 0;
  logic [7:0] s_byte = 8'h00, cap = 8'h00;
  int fall_cnt = 0, base = 0;
  logic done_run = 1'b0;

  always #10 clk = ~clk;

  spi_lp_master #(.DIV_HALF(HALF)) u_spi_lp_master (
    .clk_i(clk), .rst_ni(rst_ni), .wait_i(wait_i), .stop_i(stop_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .ss_no(ss_no), .irq_o(irq_o)
  );

  // slave model: captures MOSI on rising, advances on falling
  always @(posedge sclk_o) cap <= {cap[6:0], mosi_o};
  always @(negedge sclk_o) fall_cnt <= fall_cnt + 1;
  always_comb begin
    int idx;
    idx = fall_cnt - base;
    miso_i = (idx >= 0 && idx < 8) ? s_byte[3'(7 - idx)] : 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic start_xfer(input bit rd, input logic [7:0] tx, input logic [7:0] sb);
    s_byte = sb;
    base = fall_cnt;
    reg_wr(rd ? 2'd3 : 2'd0, tx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, tx, sb, prev_rx;
    int n;
    repeat (3) @(negedge clk);
    chk(ss_no == 4'hF, "R10 ss high in reset", ss_no, 4'hF);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), v);
      chk(v == 8'h00, "R1 slot clear", v, 0);
    end
    chk(ss_no == 4'hF && !sclk_o && !irq_o, "R1 outputs idle", {ss_no, sclk_o, irq_o}, 8'h3C);

    // R2 select mapping
    reg_wr(2'd2, 8'h05);
    chk(ss_no == 4'hF, "R2 disabled selects high", ss_no, 4'hF);
    reg_wr(2'd1, 8'h03);
    chk(ss_no == 4'hA, "R2 enabled selects", ss_no, 4'hA);

    // R5 illegal read masks
    for (int m = 0; m < 16; m++) begin
      if ($countones(m) != 1) begin
        reg_wr(2'd2, 8'(m));
        start_xfer(1'b1, 8'h5A, 8'hC3);
        repeat (4) @(negedge clk);
        chk(!sclk_o && !irq_o, "R5 no transfer", sclk_o, 0);
        reg_rd(2'd3, v);
        chk(v == 8'h02, "R5 error flag set", v, 8'h02);
        reg_rd(2'd3, v);
        chk(v == 8'h00, "R5 error cleared by read", v, 0);
      end
    end

    // R4/R3/R7 exchange sweep
    for (int i = 0; i < 32; i++) begin
      tx = 8'(i * 37 + 5);
      sb = 8'(~(i * 11) ^ 8'h96);
      reg_wr(2'd2, 8'(1 << (i % 4)));
      start_xfer(1'b1, tx, sb);
      chk(ss_no == ~4'(1 << (i % 4)), "R4 one select low", ss_no, ~4'(1 << (i % 4)));
      reg_rd(2'd3, v);
      chk(v == 8'h04, "R7 busy status", v, 8'h04);
      wait_irq(n);
      n = n + 2;
      chk(n == XFER, "R3 transfer length", n, XFER);
      chk(cap == tx, "R3 MOSI msb first", cap, tx);
      reg_rd(2'd0, v);
      chk(v == sb, "R4 received byte", v, sb);
      @(negedge clk);
      chk(!irq_o, "R7 done cleared by data read", irq_o, 0);
    end
    prev_rx = v;

    // R3 sends with broadcast mask leave rx slot alone
    reg_wr(2'd2, 8'h0F);
    for (int i = 0; i < 8; i++) begin
      tx = 8'(i * 29 + 1);
      start_xfer(1'b0, tx, 8'hFF);
      chk(ss_no == 4'h0, "R3 broadcast selects", ss_no, 0);
      wait_irq(n);
      chk(n == XFER, "R3 send length", n, XFER);
      chk(cap == tx, "R3 send byte", cap, tx);
      reg_rd(2'd0, v);
      chk(v == prev_rx, "R3 rx slot untouched", v, prev_rx);
    end

    // R6 writes ignored while busy
    reg_wr(2'd2, 8'h02);
    start_xfer(1'b1, 8'h81, 8'h3C);
    reg_wr(2'd2, 8'h0C);
    reg_wr(2'd0, 8'hEE);
    reg_wr(2'd3, 8'hEE);
    wait_irq(n);
    chk(cap == 8'h81, "R6 restart ignored", cap, 8'h81);
    reg_rd(2'd2, v);
    chk(v == 8'h02, "R6 mask kept", v, 8'h02);
    reg_rd(2'd0, v);
    chk(v == 8'h3C, "R6 rx intact", v, 8'h3C);

    // R8 wait has no effect
    wait_i = 1'b1;
    start_xfer(1'b1, 8'hA7, 8'h19);
    wait_irq(n);
    chk(n == XFER, "R8 length under wait", n, XFER);
    reg_rd(2'd0, v);
    chk(v == 8'h19, "R8 rx under wait", v, 8'h19);
    wait_i = 1'b0;

    // R9 stop freezes then resumes
    for (int d = 3; d < 30; d += 7) begin
      logic hs, hm;
      int ok;
      start_xfer(1'b1, 8'(8'h6D + d), 8'(8'hB2 ^ d));
      repeat (d) @(negedge clk);
      stop_i = 1'b1;
      hs = sclk_o; hm = mosi_o; ok = 1;
      repeat (40) begin
        @(negedge clk);
        if (sclk_o != hs || mosi_o != hm) ok = 0;
      end
      chk(ok == 1, "R9 lines frozen", ok, 1);
      chk(!irq_o, "R9 no completion while stopped", irq_o, 0);
      stop_i = 1'b0;
      wait_irq(n);
      chk(cap == 8'(8'h6D + d), "R9 resumed send", cap, 8'(8'h6D + d));
      reg_rd(2'd0, v);
      chk(v == 8'(8'hB2 ^ d), "R9 resumed receive", v, 8'(8'hB2 ^ d));
    end

    // R10 reset while stopped
    start_xfer(1'b1, 8'h33, 8'h44);
    repeat (7) @(negedge clk);
    stop_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(ss_no == 4'hF, "R10 selects high in reset", ss_no, 4'hF);
    stop_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), v);
      chk(v == 8'h00, "R10 slot cleared", v, 0);
    end
    repeat (XFER) @(negedge clk);
    chk(!sclk_o && !irq_o && ss_no == 4'hF, "R10 block disabled", {ss_no, sclk_o, irq_o}, 8'h3C);

    done_run = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule